// File: doc/BRIEF.md
# Flash Calibration Address Remap Unit

This block sits in front of a flash array and redirects selected read accesses to an overlay RAM, so that calibration constants can be swapped at runtime without reprogramming flash. Each incoming request carries a master number and an address. The unit compares the address against a table of programmable region descriptors. When an enabled descriptor covers the address and the requesting master is allowed, the access is steered to the overlay RAM. Otherwise the address goes through untouched.

Software fills the table through a write-only register port. Each descriptor has three words: a flash-side start address, an overlay-side start address, and a word that holds a master permission mask and a region size code. A separate register enables individual descriptors. A control bit turns all remapping on or off. Every request gets a response one cycle later, carrying the translated address and a hit flag.

Top module: `remap_unit`

## Requirements
- R1: After reset all configuration state is zero. Every request then passes through unchanged with the hit flag low, and `rsp_valid` is low until the first request.
- R2: Bit 0 of the control register at byte offset 0x000 is the global switch. While it is 0, no descriptor produces a hit.
- R3: The descriptor enable register sits at byte offset 0x004. Bit (31 - n) enables descriptor n, so descriptor 0 uses bit 31 and descriptor 31 uses bit 0.
- R4: Descriptor n occupies byte offsets 0x100 + 16*n. Its logical start address is at +0x0, its physical start word at +0x4, and its mask and size word at +0x8. Writes to +0xC are ignored.
- R5: The physical start word keeps only bits 31:4. Bits 3:0 of a write to it are discarded, so the physical start is (written value AND 0xFFFFFFF0).
- R6: The size code is bits 4:0 of the mask and size word, and the region spans 2^code bytes. Codes below 5 act as 5, so the smallest region is 32 bytes.
- R7: Matching compares only the address bits at or above the region size. The low bits of the logical start address are ignored.
- R8: Bits 31:16 of the mask and size word are master permissions. Bit (31 - m) lets master m be remapped. A master whose bit is clear always misses.
- R9: On a hit the response address is the physical start plus (request address mod region size), with the hit flag high. On a miss the request address is returned unchanged with the hit flag low.
- R10: When several enabled descriptors match, the lowest-numbered one supplies the translation.
- R11: Each request accepted on a clock edge yields exactly one response on the next edge. Requests may come every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Lookup request valid |
| req_master | input | 4 | Requesting master number |
| req_addr | input | 32 | Flash-side request address |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Response was remapped |
| rsp_addr | output | 32 | Translated or passed-through address |

## Verification
The bench builds the unit with its defaults: 32 descriptors, 16 masters and a 12-bit configuration offset. With these values it can reach descriptor 31, whose enable is bit 0, and master numbers at both ends of the permission field. A reference model inside the bench mirrors every configuration write. It predicts each response from the requirements, including region boundaries one byte inside and outside, clamped size codes, overlapping descriptors and back-to-back requests.

// File: rtl/remap_pkg.sv
package remap_pkg;

  localparam int ADDR_W   = 32;
  localparam int CODE_W   = 5;
  localparam int PERM_W   = 16;
  localparam int MIN_CODE = 5;
  localparam int PHYS_LSB = 4;

  typedef struct packed {
    logic [ADDR_W-1:0]          log_start;
    logic [ADDR_W-PHYS_LSB-1:0] phys_field;
    logic [PERM_W-1:0]          perm;
    logic [CODE_W-1:0]          size_code;
  } region_t;

  // Bits set at and above the region size; clamps small codes to the minimum.
  function automatic logic [ADDR_W-1:0] region_keep(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] eff;
    eff = (code < CODE_W'(MIN_CODE)) ? CODE_W'(MIN_CODE) : code;
    return ~((ADDR_W'(1) << eff) - ADDR_W'(1));
  endfunction

endpackage

// File: rtl/remap_regs.sv
module remap_regs
  import remap_pkg::*;
#(
  parameter int NUM_DESC = 32,
  parameter int REG_AW   = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [REG_AW-1:0]          wr_addr,
  input  logic [31:0]                wr_data,
  output logic                       glob_en,
  output logic [31:0]                desc_en,
  output region_t [NUM_DESC-1:0]     regions
);

  localparam int IDX_W = $clog2(NUM_DESC);
  localparam logic [REG_AW-1:0] CTRL_OFF  = REG_AW'(0);
  localparam logic [REG_AW-1:0] EN_OFF    = REG_AW'(4);
  localparam logic [REG_AW-1:0] TBL_BASE  = REG_AW'(256);
  localparam logic [REG_AW-1:0] TBL_SPAN  = REG_AW'(NUM_DESC * 16);

  logic [REG_AW-1:0] tbl_off;
  logic              in_tbl;
  logic [IDX_W-1:0]  sel_idx;
  logic [1:0]        sel_word;
  region_t           store [NUM_DESC];

  assign tbl_off  = wr_addr - TBL_BASE;
  assign in_tbl   = (wr_addr >= TBL_BASE) && (tbl_off < TBL_SPAN);
  assign sel_idx  = tbl_off[4 +: IDX_W];
  assign sel_word = tbl_off[3:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en <= 1'b0;
      desc_en <= '0;
    end else if (wr_en) begin
      if (wr_addr == CTRL_OFF) glob_en <= wr_data[0];
      if (wr_addr == EN_OFF)   desc_en <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    for (int n = 0; n < NUM_DESC; n++) begin
      if (rst) begin
        store[n] <= '0;
      end else if (wr_en && in_tbl && sel_idx == IDX_W'(n)) begin
        case (sel_word)
          2'd0: store[n].log_start  <= wr_data;
          2'd1: store[n].phys_field <= wr_data[31:PHYS_LSB];
          2'd2: begin
            store[n].perm      <= wr_data[31:16];
            store[n].size_code <= wr_data[CODE_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar n = 0; n < NUM_DESC; n++) begin : g_out
    assign regions[n] = store[n];
  end

  logic unused_bits;
  assign unused_bits = ^{wr_addr[1:0], tbl_off[1:0], wr_data[15:CODE_W]};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!glob_en && desc_en == 32'd0 && regions[0] == '0));

  p_phys_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == TBL_BASE + REG_AW'(4))
      |=> regions[0].phys_field == $past(wr_data[31:PHYS_LSB]));

endmodule

// File: rtl/remap_match.sv
module remap_match
  import remap_pkg::*;
#(
  parameter int NUM_DESC    = 32,
  parameter int NUM_MASTERS = 16,
  parameter int MID_W       = $clog2(NUM_MASTERS)
) (
  input  logic                              glob_en,
  input  logic [31:0]                       desc_en,
  input  region_t [NUM_DESC-1:0]            regions,
  input  logic [MID_W-1:0]                  req_master,
  input  logic [ADDR_W-1:0]                 req_addr,
  output logic [NUM_DESC-1:0]               hit_vec,
  output logic [NUM_DESC-1:0][ADDR_W-1:0]   xlat
);

  for (genvar n = 0; n < NUM_DESC; n++) begin : g_cmp
    logic [ADDR_W-1:0] keep;
    logic [PERM_W-1:0] perm_sh;
    logic              perm_ok;
    logic              addr_ok;

    assign keep    = region_keep(regions[n].size_code);
    assign perm_sh = regions[n].perm << req_master;
    assign perm_ok = perm_sh[PERM_W-1];
    assign addr_ok = ((req_addr ^ regions[n].log_start) & keep) == '0;

    assign hit_vec[n] = glob_en && desc_en[31-n] && perm_ok && addr_ok;
    assign xlat[n]    = {regions[n].phys_field, {PHYS_LSB{1'b0}}} + (req_addr & ~keep);
  end

endmodule

// File: rtl/remap_select.sv
module remap_select
  import remap_pkg::*;
#(
  parameter int NUM_DESC = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req_valid,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [NUM_DESC-1:0]             hit_vec,
  input  logic [NUM_DESC-1:0][ADDR_W-1:0] xlat,
  output logic                            rsp_valid,
  output logic                            rsp_hit,
  output logic [ADDR_W-1:0]               rsp_addr
);

  logic [NUM_DESC-1:0] win;
  logic [ADDR_W-1:0]   nxt_addr;
  logic                any_hit;

  // Walk from the top so the lowest-numbered match is the final assignment.
  always_comb begin
    win      = '0;
    nxt_addr = req_addr;
    any_hit  = 1'b0;
    for (int n = NUM_DESC - 1; n >= 0; n--) begin
      if (hit_vec[n]) begin
        win      = '0;
        win[n]   = 1'b1;
        nxt_addr = xlat[n];
        any_hit  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit  <= any_hit;
        rsp_addr <= nxt_addr;
      end
    end
  end

  p_one_winner_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win));

  p_lowest_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hit_vec[0]) |=> (rsp_hit && rsp_addr == $past(xlat[0])));

  p_miss_passes_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hit_vec == '0) |=> (!rsp_hit && rsp_addr == $past(req_addr)));

  p_resp_follows_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

endmodule

// File: rtl/remap_unit.sv
module remap_unit
  import remap_pkg::*;
#(
  parameter int NUM_DESC    = 32,
  parameter int NUM_MASTERS = 16,
  parameter int REG_AW      = 12,
  parameter int MID_W       = $clog2(NUM_MASTERS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [MID_W-1:0]  req_master,
  input  logic [31:0]       req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [31:0]       rsp_addr
);

  logic                            glob_en;
  logic [31:0]                     desc_en;
  region_t [NUM_DESC-1:0]          regions;
  logic [NUM_DESC-1:0]             hit_vec;
  logic [NUM_DESC-1:0][ADDR_W-1:0] xlat;

  remap_regs #(.NUM_DESC(NUM_DESC), .REG_AW(REG_AW)) i_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .glob_en (glob_en),
    .desc_en (desc_en),
    .regions (regions)
  );

  remap_match #(.NUM_DESC(NUM_DESC), .NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W)) i_match (
    .glob_en    (glob_en),
    .desc_en    (desc_en),
    .regions    (regions),
    .req_master (req_master),
    .req_addr   (req_addr),
    .hit_vec    (hit_vec),
    .xlat       (xlat)
  );

  remap_select #(.NUM_DESC(NUM_DESC)) i_select (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .hit_vec   (hit_vec),
    .xlat      (xlat),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_addr  (rsp_addr)
  );

  p_global_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !glob_en |-> hit_vec == '0);

  for (genvar n = 0; n < NUM_DESC; n++) begin : g_chk
    p_desc_gate_r3: assert property (@(posedge clk) disable iff (rst)
      !desc_en[31-n] |-> !hit_vec[n]);
  end

endmodule

// File: tb/test_remap_unit.sv
module test_remap_unit;

  localparam int ND = 32;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr_en;
  logic [11:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [3:0]  req_master;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [31:0] rsp_addr;

  always #2 clk = ~clk;

  remap_unit i_remap_unit (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_master(req_master),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_addr(rsp_addr)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] m_w0 [ND];
  logic [31:0] m_w1 [ND];
  logic [31:0] m_w2 [ND];
  logic [31:0] m_den;
  logic        m_gen;

  typedef struct {
    logic [31:0] addr;
    logic        hit;
    string       tag;
  } exp_t;
  exp_t sb [$];

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_wr_en = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    if (a == 12'h000) m_gen = d[0];
    else if (a == 12'h004) m_den = d;
    else if (a >= 12'h100 && a < 12'h300) begin
      int n = int'((a - 12'h100) >> 4);
      case (a[3:2])
        2'd0: m_w0[n] = d;
        2'd1: m_w1[n] = d & 32'hFFFF_FFF0;
        2'd2: m_w2[n] = d;
        default: ;
      endcase
    end
  endtask

  task automatic wdesc(input int n, input logic [31:0] w0, input logic [31:0] w1,
                       input logic [31:0] w2);
    logic [11:0] b;
    b = 12'h100 + 12'(n * 16);
    wr(b, w0);
    wr(b + 12'h4, w1);
    wr(b + 12'h8, w2);
  endtask

  task automatic req(input logic [3:0] m, input logic [31:0] a, input string tag);
    exp_t e;
    logic [31:0] keep;
    logic [4:0]  code;
    @(negedge clk);
    cfg_wr_en  = 1'b0;
    req_valid  = 1'b1;
    req_master = m;
    req_addr   = a;
    e.addr = a;
    e.hit  = 1'b0;
    e.tag  = tag;
    if (m_gen) begin
      for (int n = 0; n < ND; n++) begin
        if (!e.hit && m_den[31-n] && m_w2[n][31-m]) begin
          code = m_w2[n][4:0];
          if (code < 5'd5) code = 5'd5;
          keep = ~((32'h1 << code) - 32'h1);
          if (((a ^ m_w0[n]) & keep) == 32'h0) begin
            e.hit  = 1'b1;
            e.addr = m_w1[n] + (a & ~keep);
          end
        end
      end
    end
    sb.push_back(e);
  endtask

  task automatic idle(input int k);
    repeat (k) begin
      @(negedge clk);
      req_valid = 1'b0;
      cfg_wr_en = 1'b0;
    end
  endtask

  // Monitor: pops the oldest expectation whenever a response appears.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R11: response with nothing outstanding, addr=%h expected none", rsp_addr);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rsp_hit !== e.hit || rsp_addr !== e.addr) begin
          errors++;
          $display("FAIL %s: hit=%b addr=%h expected hit=%b addr=%h",
                   e.tag, rsp_hit, rsp_addr, e.hit, e.addr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int n = 0; n < ND; n++) begin
      m_w0[n] = '0; m_w1[n] = '0; m_w2[n] = '0;
    end
    m_den = '0; m_gen = 1'b0;
    rst = 1'b1; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_master = '0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid=%b hit=%b expected 0 0", rsp_valid, rsp_hit);
    end
    req(4'd0, 32'h0945_7E99, "R1");

    // Descriptor 1: 128-byte region, all masters, enabled via bit 30.
    wdesc(1, 32'h0945_7E80, 32'h0D00_0000, 32'hFFFF_0007);
    wr(12'h004, 32'h4000_0000);
    req(4'd0, 32'h0945_7E99, "R2");
    wr(12'h000, 32'h1);
    req(4'd0, 32'h0945_7E99, "R9");
    req(4'd0, 32'h0945_7EFF, "R6");
    req(4'd0, 32'h0945_7F00, "R6");
    req(4'd3, 32'h0945_7E7F, "R9");

    // Only master 1 permitted.
    wr(12'h118, 32'h4000_0007);
    req(4'd0, 32'h0945_7E99, "R8");
    req(4'd1, 32'h0945_7E99, "R8");
    req(4'd15, 32'h0945_7E99, "R8");

    // Physical word low nibble discarded.
    wr(12'h114, 32'h0D00_004F);
    req(4'd1, 32'h0945_7E81, "R5");

    // Size code below the minimum acts as 32 bytes.
    wr(12'h118, 32'hFFFF_0002);
    req(4'd2, 32'h0945_7E9F, "R6");
    req(4'd2, 32'h0945_7EA0, "R6");

    // Low bits of the logical start ignored.
    wr(12'h110, 32'h0945_7E99);
    req(4'd2, 32'h0945_7E85, "R7");

    // Overlap: descriptor 0 (256 bytes) also covers the address.
    wdesc(0, 32'h0945_7E00, 32'h0C00_0000, 32'hFFFF_0008);
    wr(12'h004, 32'hC000_0000);
    req(4'd2, 32'h0945_7E85, "R10");
    req(4'd2, 32'h0945_7E10, "R10");

    // Descriptor 31 enabled by bit 0 only.
    wdesc(31, 32'h0000_1000, 32'h0D00_1000, 32'h8000_0005);
    wr(12'h004, 32'h0000_0001);
    req(4'd0, 32'h0000_1010, "R3");
    req(4'd0, 32'h0945_7E85, "R3");
    wr(12'h004, 32'h8000_0000);
    req(4'd0, 32'h0000_1010, "R3");

    // Descriptor 17 placement and an ignored fourth word.
    wdesc(17, 32'h2000_0000, 32'h0C10_0000, 32'h0001_000A);
    wr(12'h21C, 32'hFFFF_FFFF);
    wr(12'h004, 32'h0000_4000);
    req(4'd15, 32'h2000_03FF, "R4");
    req(4'd14, 32'h2000_03FF, "R4");

    // Back-to-back stream.
    wr(12'h004, 32'hC000_4001);
    req(4'd15, 32'h2000_0004, "R11");
    req(4'd0, 32'h0000_101F, "R11");
    req(4'd0, 32'h0945_7E20, "R11");
    req(4'd0, 32'h3000_0000, "R11");
    idle(1);

    // Global switch off again.
    wr(12'h000, 32'h0);
    req(4'd0, 32'h0945_7E20, "R2");
    idle(4);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11: %0d responses missing, expected 0", sb.size());
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule